// File: doc/BRIEF.md
# SPI Flash Write-Protection Controller

This block decides, for a small serial flash memory, which instructions may change the array or the status register. It sits behind the serial shifter. At the end of each chip-select frame it receives the decoded opcode, the target address, the status data byte and the number of serial clock pulses counted in that frame. It also watches the write-protect pin and the completion pulse from the program/erase engine. It holds the volatile status bits and starts the engine only when every protection gate agrees. Any instruction that fails a gate is dropped without trace.

The gates are checked together. The write enable latch must already be set. Modifying frames must be an exact multiple of eight clocks long. The target must lie outside the region named by the block protect bits. Status writes are refused when the status write disable bit is set and the write-protect pin is held low. Deep power-down locks out everything except the release opcode. A power-up timer keeps every instruction out for a programmable number of cycles after reset. While an operation runs, all instructions are ignored. The engine's completion pulse ends the busy state and clears the latch.

Top module: `spi_wp_ctrl`

## Requirements
- R1: During and right after reset, status is 0x00, and deep_pd, launch and ready are all 0.
- R2: ready rises once PU_CYCLES cycles have passed after reset is released. Every frame presented before that has no effect on any output.
- R3: Opcode 0x06 (write enable) sets status bit 1, the write enable latch. Page program 0x02, sector erase 0xD8, bulk erase 0xC7 and write status 0x01 are ignored while that bit is 0.
- R4: Opcodes 0x02, 0xD8, 0xC7 and 0x01 are ignored unless cmd_clks is a multiple of eight (low three bits zero).
- R5: An accepted modifying instruction sets status bit 0 (write in progress). It also drives launch high for exactly one cycle, on the cycle after the frame. launch_kind encodes the operation: 0 write status, 1 page program, 2 sector erase, 3 bulk erase.
- R6: eng_done while bit 0 is set clears bits 0 and 1 on the next cycle. eng_done while bit 0 is clear changes nothing.
- R7: Opcode 0x04 (write disable) clears status bit 1.
- R8: Page program and sector erase are ignored if the sector in the top log2(SECTORS) address bits is protected. Status bits 3:2 select the protected region: 00 none, 01 the top sector, 10 the top two sectors, 11 every sector.
- R9: Bulk erase is ignored while either of status bits 3:2 is 1.
- R10: While status bit 0 is set, every frame is ignored.
- R11: An accepted write status copies cmd_data bit 7 into status bit 7 (status write disable) and cmd_data bits 3:2 into status bits 3:2. Status bits 6:4 always read 0.
- R12: When status bit 7 is 1 and wp_n is 0, write status is ignored and bits 7 and 3:2 stay unchanged.
- R13: Opcode 0xB9 sets deep_pd. While deep_pd is set, every opcode except 0xAB is ignored. 0xAB clears deep_pd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | One-cycle pulse: a completed frame is presented |
| cmd_op | input | 8 | Decoded opcode |
| cmd_addr | input | ADDR_W | Target byte address |
| cmd_clks | input | CNT_W | Serial clock pulses counted in the frame |
| cmd_data | input | 8 | Status byte for write status |
| wp_n | input | 1 | Write-protect pin, active low |
| eng_done | input | 1 | Completion pulse from the program/erase engine |
| status | output | 8 | Status register image |
| ready | output | 1 | Power-up delay has expired |
| deep_pd | output | 1 | Deep power-down active |
| launch | output | 1 | One-cycle start pulse to the engine |
| launch_kind | output | 2 | Operation started by launch |

## Verification
The hardest state to reach is one where several gates apply at once. Examples: a set write enable latch with protection bits already programmed, a low write-protect pin with status write disable set, or a latch left set while the block sits in deep power-down. Each case needs its own accepted write status and engine completion before it can be reached. The stimulus therefore builds the protection state one step at a time. It first programs the block protect bits and the disable bit through accepted write-status frames. It then re-arms the latch and presents frames that differ from each other in a single gate, so each frame checks one gate in isolation. A reference model in the bench follows every frame and completion pulse and queues the expected status for each one.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_PP   = 8'h02;
  localparam logic [7:0] OP_SE   = 8'hD8;
  localparam logic [7:0] OP_BE   = 8'hC7;
  localparam logic [7:0] OP_DP   = 8'hB9;
  localparam logic [7:0] OP_RES  = 8'hAB;

  typedef enum logic [1:0] {
    KIND_WRSR = 2'd0,
    KIND_PP   = 2'd1,
    KIND_SE   = 2'd2,
    KIND_BE   = 2'd3
  } op_kind_t;
endpackage

// File: rtl/wpc_powerup_timer.sv
module wpc_powerup_timer #(
  parameter int PU_CYCLES = 64
) (
  input  logic clk,
  input  logic rst,
  output logic ready
);
  localparam int CW = $clog2(PU_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(PU_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (cnt_q != LIMIT) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign ready = (cnt_q == LIMIT);
endmodule

// File: rtl/wpc_protect_decode.sv
module wpc_protect_decode #(
  parameter int ADDR_W  = 17,
  parameter int SECTORS = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        bp,
  output logic              prot
);
  localparam int SEC_W = (SECTORS > 1) ? $clog2(SECTORS) : 1;
  localparam logic [SEC_W:0] TOTAL = (SEC_W+1)'(SECTORS);

  logic [SEC_W-1:0] sector;
  logic [SEC_W:0]   n_prot;
  logic [SEC_W:0]   first;

  assign sector = addr[ADDR_W-1 -: SEC_W];

  always_comb begin
    case (bp)
      2'b00:   n_prot = '0;
      2'b01:   n_prot = (SEC_W+1)'(1);
      2'b10:   n_prot = (TOTAL >= (SEC_W+1)'(2)) ? (SEC_W+1)'(2) : TOTAL;
      default: n_prot = TOTAL;
    endcase
    first = TOTAL - n_prot;
    prot  = (n_prot != '0) && ({1'b0, sector} >= first);
  end
endmodule

// File: rtl/wpc_gate.sv
module wpc_gate
  import wpc_pkg::*;
#(
  parameter int ADDR_W  = 17,
  parameter int CNT_W   = 12,
  parameter int SECTORS = 4
) (
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [CNT_W-1:0]  cmd_clks,
  input  logic              wp_n,
  input  logic              ready,
  input  logic              wip,
  input  logic              wel,
  input  logic              srwd,
  input  logic [1:0]        bp,
  input  logic              dpd,
  output logic              acc_wren,
  output logic              acc_wrdi,
  output logic              acc_dp,
  output logic              acc_res,
  output logic              acc_launch,
  output op_kind_t          kind
);
  logic prot;
  logic live, awake, wr_ok;

  wpc_protect_decode #(.ADDR_W(ADDR_W), .SECTORS(SECTORS)) u_prot (
    .addr (cmd_addr),
    .bp   (bp),
    .prot (prot)
  );

  assign live  = cmd_valid && ready && !wip;
  assign awake = live && !dpd;
  assign wr_ok = awake && wel && (cmd_clks[2:0] == 3'b000);

  assign acc_res  = live && dpd && (cmd_op == OP_RES);
  assign acc_wren = awake && (cmd_op == OP_WREN);
  assign acc_wrdi = awake && (cmd_op == OP_WRDI);
  assign acc_dp   = awake && (cmd_op == OP_DP);

  always_comb begin
    acc_launch = 1'b0;
    kind       = KIND_WRSR;
    case (cmd_op)
      OP_WRSR: begin
        kind       = KIND_WRSR;
        acc_launch = wr_ok && !(srwd && !wp_n);
      end
      OP_PP: begin
        kind       = KIND_PP;
        acc_launch = wr_ok && !prot;
      end
      OP_SE: begin
        kind       = KIND_SE;
        acc_launch = wr_ok && !prot;
      end
      OP_BE: begin
        kind       = KIND_BE;
        acc_launch = wr_ok && (bp == 2'b00);
      end
      default: begin
        kind       = KIND_WRSR;
        acc_launch = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/spi_wp_ctrl.sv
module spi_wp_ctrl
  import wpc_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int CNT_W     = 12,
  parameter int SECTORS   = 4,
  parameter int PU_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [CNT_W-1:0]  cmd_clks,
  input  logic [7:0]        cmd_data,
  input  logic              wp_n,
  input  logic              eng_done,
  output logic [7:0]        status,
  output logic              ready,
  output logic              deep_pd,
  output logic              launch,
  output logic [1:0]        launch_kind
);
  logic       srwd_q, wel_q, wip_q, dpd_q, launch_q;
  logic [1:0] bp_q;
  op_kind_t   kind_q;

  logic     acc_wren, acc_wrdi, acc_dp, acc_res, acc_launch;
  op_kind_t kind;

  wpc_powerup_timer #(.PU_CYCLES(PU_CYCLES)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .ready (ready)
  );

  wpc_gate #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .SECTORS(SECTORS)) u_gate (
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_addr   (cmd_addr),
    .cmd_clks   (cmd_clks),
    .wp_n       (wp_n),
    .ready      (ready),
    .wip        (wip_q),
    .wel        (wel_q),
    .srwd       (srwd_q),
    .bp         (bp_q),
    .dpd        (dpd_q),
    .acc_wren   (acc_wren),
    .acc_wrdi   (acc_wrdi),
    .acc_dp     (acc_dp),
    .acc_res    (acc_res),
    .acc_launch (acc_launch),
    .kind       (kind)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      srwd_q   <= 1'b0;
      bp_q     <= 2'b00;
      wel_q    <= 1'b0;
      wip_q    <= 1'b0;
      dpd_q    <= 1'b0;
      launch_q <= 1'b0;
      kind_q   <= KIND_WRSR;
    end else begin
      launch_q <= 1'b0;
      if (eng_done && wip_q) begin
        wip_q <= 1'b0;
        wel_q <= 1'b0;
      end else begin
        if (acc_wren) wel_q <= 1'b1;
        if (acc_wrdi) wel_q <= 1'b0;
        if (acc_dp)   dpd_q <= 1'b1;
        if (acc_res)  dpd_q <= 1'b0;
        if (acc_launch) begin
          wip_q    <= 1'b1;
          launch_q <= 1'b1;
          kind_q   <= kind;
          if (kind == KIND_WRSR) begin
            srwd_q <= cmd_data[7];
            bp_q   <= cmd_data[3:2];
          end
        end
      end
    end
  end

  assign status      = {srwd_q, 3'b000, bp_q, wel_q, wip_q};
  assign deep_pd     = dpd_q;
  assign launch      = launch_q;
  assign launch_kind = kind_q;
endmodule

// File: rtl/wpc_checker.sv
module wpc_checker #(
  parameter int ADDR_W = 17,
  parameter int CNT_W  = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic [7:0]        cmd_op,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [CNT_W-1:0]  cmd_clks,
  input logic [7:0]        cmd_data,
  input logic              wp_n,
  input logic              eng_done,
  input logic [7:0]        status,
  input logic              ready,
  input logic              deep_pd,
  input logic              launch,
  input logic [1:0]        launch_kind
);
  assert_wel_from_wren_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(status[1]) |-> $past(cmd_valid && cmd_op == 8'h06));

  assert_launch_needs_wel_R3: assert property (@(posedge clk) disable iff (rst)
    launch |-> $past(status[1]));

  assert_launch_mod8_R4: assert property (@(posedge clk) disable iff (rst)
    launch |-> $past(cmd_clks[2:0] == 3'b000));

  assert_launch_sets_wip_R5: assert property (@(posedge clk) disable iff (rst)
    launch |-> status[0]);

  assert_done_clears_R6: assert property (@(posedge clk) disable iff (rst)
    (eng_done && status[0]) |=> (!status[0] && !status[1]));

  assert_busy_stable_R10: assert property (@(posedge clk) disable iff (rst)
    (status[0] && !eng_done) |=> ($stable(status[7:2]) && !launch));

  assert_hw_protect_R12: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 8'h01 && status[7] && !wp_n) |=> !launch);

  assert_pd_blocks_R13: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && deep_pd) |=> !launch);

  assert_powerup_block_R2: assert property (@(posedge clk) disable iff (rst)
    !ready |=> !launch);

  assert_zero_bits_R11: assert property (@(posedge clk) disable iff (rst)
    status[6:4] == 3'b000);
endmodule

bind spi_wp_ctrl wpc_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_spi_wp_ctrl.sv
module sim_spi_wp_ctrl;
  localparam int ADDR_W = 17;
  localparam int CNT_W  = 12;
  localparam int PU     = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cmd_valid = 1'b0;
  logic [7:0]        cmd_op = '0;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic [CNT_W-1:0]  cmd_clks = '0;
  logic [7:0]        cmd_data = '0;
  logic              wp_n = 1'b1;
  logic              eng_done = 1'b0;
  logic [7:0]        status;
  logic              ready, deep_pd, launch;
  logic [1:0]        launch_kind;

  int tests = 0;
  int fails = 0;

  logic       m_ready = 0, m_srwd = 0, m_wel = 0, m_wip = 0, m_dpd = 0;
  logic [1:0] m_bp = 0;

  logic [7:0] q_stat[$];
  logic       q_pd[$];
  logic       q_launch[$];
  logic [1:0] q_kind[$];
  string      q_tag[$];

  always #2.5 clk = ~clk;

  spi_wp_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .SECTORS(4), .PU_CYCLES(PU)) u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_clks(cmd_clks), .cmd_data(cmd_data),
    .wp_n(wp_n), .eng_done(eng_done), .status(status), .ready(ready),
    .deep_pd(deep_pd), .launch(launch), .launch_kind(launch_kind)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic sec_prot(input logic [1:0] bp, input logic [ADDR_W-1:0] a);
    logic [1:0] s;
    s = a[ADDR_W-1 -: 2];
    case (bp)
      2'b01:   return s == 2'd3;
      2'b10:   return s >= 2'd2;
      2'b11:   return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [7:0] m_status();
    return {m_srwd, 3'b000, m_bp, m_wel, m_wip};
  endfunction

  task automatic push(input string tag, input logic ln, input logic [1:0] k);
    q_stat.push_back(m_status());
    q_pd.push_back(m_dpd);
    q_launch.push_back(ln);
    q_kind.push_back(k);
    q_tag.push_back(tag);
  endtask

  task automatic issue(input string tag, input logic [7:0] op, input logic [ADDR_W-1:0] a,
                       input logic [CNT_W-1:0] n, input logic [7:0] d);
    logic ln, ok;
    logic [1:0] k;
    ln = 0; k = 0;
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_addr = a; cmd_clks = n; cmd_data = d;
    if (m_ready && !m_wip) begin
      if (m_dpd) begin
        if (op == 8'hAB) m_dpd = 0;
      end else begin
        ok = m_wel && (n[2:0] == 3'b000);
        case (op)
          8'h06: m_wel = 1;
          8'h04: m_wel = 0;
          8'hB9: m_dpd = 1;
          8'h01: if (ok && !(m_srwd && !wp_n)) begin
                   ln = 1; k = 0; m_srwd = d[7]; m_bp = d[3:2];
                 end
          8'h02: if (ok && !sec_prot(m_bp, a)) begin ln = 1; k = 1; end
          8'hD8: if (ok && !sec_prot(m_bp, a)) begin ln = 1; k = 2; end
          8'hC7: if (ok && m_bp == 2'b00) begin ln = 1; k = 3; end
          default: ;
        endcase
        if (ln) m_wip = 1;
      end
    end
    push(tag, ln, k);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic done(input string tag);
    @(negedge clk);
    eng_done = 1;
    if (m_wip) begin m_wip = 0; m_wel = 0; end
    push(tag, 1'b0, 2'd0);
    @(negedge clk);
    eng_done = 0;
  endtask

  // monitor: pop one expected item per presented frame or completion pulse
  initial begin
    forever begin
      @(posedge clk);
      if (!rst && (cmd_valid || eng_done)) begin
        @(negedge clk);
        if (q_stat.size() == 0) begin
          check("monitor queue underflow", 1, 0);
        end else begin
          string t;
          logic ln;
          logic [1:0] k;
          t = q_tag.pop_front();
          ln = q_launch.pop_front();
          k = q_kind.pop_front();
          check({t, " status"}, status, q_stat.pop_front());
          check({t, " deep_pd"}, deep_pd, q_pd.pop_front());
          check({t, " launch"}, launch, ln);
          if (ln) check({t, " kind"}, launch_kind, k);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset status", status, 8'h00);
    check("R1 reset flags", {deep_pd, launch, ready}, 3'b000);
    rst = 0;
    issue("R2 wren before ready", 8'h06, 0, 8, 0);
    check("R2 not ready early", ready, 1'b0);
    repeat (PU + 2) @(negedge clk);
    check("R2 ready after delay", ready, 1'b1);
    m_ready = 1;

    issue("R3 pp without wel", 8'h02, 17'h00100, 40, 0);
    issue("R3 wren sets wel", 8'h06, 0, 8, 0);
    issue("R4 pp odd clocks", 8'h02, 17'h00100, 37, 0);
    issue("R4 be odd clocks", 8'hC7, 0, 9, 0);
    issue("R5 pp accepted", 8'h02, 17'h00100, 40, 0);
    issue("R10 wrdi while busy", 8'h04, 0, 8, 0);
    issue("R10 wrsr while busy", 8'h01, 0, 16, 8'h8C);
    done("R6 done clears");
    done("R6 stray done");

    issue("R7 wren", 8'h06, 0, 8, 0);
    issue("R7 wrdi clears wel", 8'h04, 0, 8, 0);

    issue("R11 wren", 8'h06, 0, 8, 0);
    issue("R11 wrsr srwd bp01", 8'h01, 0, 16, 8'h84);
    done("R11 wrsr done");
    issue("R8 wren", 8'h06, 0, 8, 0);
    issue("R8 pp top sector", 8'h02, 17'h18000, 40, 0);
    issue("R9 be with bp", 8'hC7, 0, 8, 0);
    issue("R8 se sector2 open", 8'hD8, 17'h10000, 32, 0);
    done("R8 se done");

    wp_n = 0;
    issue("R12 wren", 8'h06, 0, 8, 0);
    issue("R12 wrsr hw locked", 8'h01, 0, 16, 8'h00);
    wp_n = 1;
    issue("R12 wrsr pin high bp10", 8'h01, 0, 16, 8'h08);
    done("R12 done");
    issue("R8 wren2", 8'h06, 0, 8, 0);
    issue("R8 se sector2 locked", 8'hD8, 17'h10000, 32, 0);
    issue("R8 se sector1 open", 8'hD8, 17'h08000, 32, 0);
    done("R8 se1 done");
    issue("R9 wren", 8'h06, 0, 8, 0);
    issue("R9 clear bp", 8'h01, 0, 16, 8'h00);
    done("R9 wrsr done");
    issue("R9 wren2", 8'h06, 0, 8, 0);
    issue("R9 be accepted", 8'hC7, 0, 8, 0);
    done("R9 be done");

    issue("R13 wren", 8'h06, 0, 8, 0);
    issue("R13 dp enter", 8'hB9, 0, 8, 0);
    issue("R13 pp ignored in pd", 8'h02, 0, 40, 0);
    issue("R13 wrdi ignored in pd", 8'h04, 0, 8, 0);
    issue("R13 release", 8'hAB, 0, 8, 0);
    issue("R13 pp after release", 8'h02, 0, 40, 0);
    done("R13 done");

    repeat (4) @(negedge clk);
    check("queue drained", q_stat.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule